// File: doc/BRIEF.md
# SDRAM Command Decoder with Data-Mask Alignment

This block sits on the device side of a single-data-rate SDRAM link. On every rising clock edge it samples the chip-select, row-strobe, column-strobe and write-enable pins, the clock-enable pin, the bank pins, the address bus and the data-mask pin. It turns them into a one-hot command pulse and the address fields that command carries. All decoded outputs are registered. They are valid for exactly the one clock that follows the edge on which the pins were sampled.

Clock-enable selects between the two refresh flavours. If clock-enable is low for any other encoding, the block decodes no command and raises a separate flag instead. The data-mask pin is presented twice. The write mask appears in the same cycle as the command outputs. The read mask appears two clocks later, in the cycle where read data would be driven. Timing checks, storage, bank state tracking and burst counting belong to neighbouring blocks.

Top module: `sdram_cmd_decode`

## Requirements
- R1: While csN is sampled high, no bit of cmdOut and not illegalCke is set in the following cycle; the data-mask outputs still follow dqmIn.
- R2: With csN low and cke high, the code {rasN,casN,weN} decodes to exactly one cmdOut bit in the next cycle: 111 no-op (bit 0), 011 activate (bit 1), 101 read (bit 2), 100 write (bit 3), 110 burst stop (bit 4), 010 precharge (bit 5), 001 auto refresh (bit 6), 000 mode load (bit 8).
- R3: An activate presents addrIn on rowOut and bankIn on bankOut in the next cycle.
- R4: A read or write presents addrIn[9:0] on colOut and bankIn on bankOut, and sets autoPre to the value of addrIn[10], in the next cycle.
- R5: A precharge with addrIn[10] low presents bankIn on bankOut with preAll low. With addrIn[10] high it sets preAll and presents bankOut as zero, whatever bankIn holds.
- R6: Code 001 with csN low decodes to auto refresh (bit 6) when cke is high and to self-refresh entry (bit 7) when cke is low.
- R7: With csN low and cke low, any code other than 001 produces no cmdOut bit and sets illegalCke in the next cycle.
- R8: A mode load pulses modeStrobe and presents addrIn[11:0] on modeOp in the next cycle.
- R9: wrMaskEn equals the dqmIn sampled on the same edge as the command, with one register of delay.
- R10: rdMaskEn equals the dqmIn sampled two edges earlier than the value wrMaskEn shows.
- R11: Reset clears every output. bankOut, rowOut, colOut and modeOp read zero in any cycle whose command does not carry them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Asynchronous reset, active low |
| csN | input | 1 | Chip select, active low |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write enable, active low |
| cke | input | 1 | Clock enable |
| bankIn | input | 2 | Bank select pins |
| addrIn | input | 13 | Address bus |
| dqmIn | input | 1 | Data-mask pin |
| cmdOut | output | 9 | One-hot decoded command |
| illegalCke | output | 1 | Command attempted with cke low |
| bankOut | output | 2 | Bank carried by the command |
| rowOut | output | 13 | Row address of an activate |
| colOut | output | 10 | Column of a read or write |
| autoPre | output | 1 | Auto-precharge requested by a read or write |
| preAll | output | 1 | Precharge of every bank |
| modeStrobe | output | 1 | Mode load pulse |
| modeOp | output | 12 | Mode op-code |
| wrMaskEn | output | 1 | Write data mask for this cycle |
| rdMaskEn | output | 1 | Read output disable for this cycle |

## Verification
The bench builds the block with its default parameters. With those values a 13-bit row reaches addrIn[12], a 10-bit column keeps addrIn[10] out of colOut, and a 12-bit op-code drops addrIn[12]. A read-mask delay of two brings the cycle-exact lag of rdMaskEn behind wrMaskEn within reach. It also lets a sweep over all 32 pin combinations of chip select, clock enable and the three strobes cover the whole decode table, including every clock-enable fault.

// File: rtl/sdram_cmd_pkg.sv
package sdram_cmd_pkg;
  localparam int CMD_NUM  = 9;
  localparam int CMD_NOP  = 0;
  localparam int CMD_ACT  = 1;
  localparam int CMD_RD   = 2;
  localparam int CMD_WR   = 3;
  localparam int CMD_BST  = 4;
  localparam int CMD_PRE  = 5;
  localparam int CMD_AREF = 6;
  localparam int CMD_SREF = 7;
  localparam int CMD_LMR  = 8;

  // strobes handed from the control decode to the field datapath
  typedef struct packed {
    logic isAct;
    logic isAccess;
    logic isPre;
    logic isLmr;
  } strobe_t;
endpackage

// File: rtl/sdram_cmd_ctrl.sv
module sdram_cmd_ctrl
  import sdram_cmd_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               csN,
  input  logic               rasN,
  input  logic               casN,
  input  logic               weN,
  input  logic               cke,
  output strobe_t            strobes,
  output logic [CMD_NUM-1:0] cmdOut,
  output logic               illegalCke
);
  logic [2:0]         code;
  logic [CMD_NUM-1:0] decVec;
  logic               illegalNext;

  assign code = {rasN, casN, weN};

  always_comb begin
    decVec      = '0;
    illegalNext = 1'b0;
    if (!csN) begin
      if (cke) begin
        case (code)
          3'b111:  decVec[CMD_NOP]  = 1'b1;
          3'b011:  decVec[CMD_ACT]  = 1'b1;
          3'b101:  decVec[CMD_RD]   = 1'b1;
          3'b100:  decVec[CMD_WR]   = 1'b1;
          3'b110:  decVec[CMD_BST]  = 1'b1;
          3'b010:  decVec[CMD_PRE]  = 1'b1;
          3'b001:  decVec[CMD_AREF] = 1'b1;
          3'b000:  decVec[CMD_LMR]  = 1'b1;
          default: ;
        endcase
      end else if (code == 3'b001) begin
        decVec[CMD_SREF] = 1'b1;
      end else begin
        illegalNext = 1'b1;
      end
    end
  end

  always_comb begin
    strobes.isAct    = decVec[CMD_ACT];
    strobes.isAccess = decVec[CMD_RD] | decVec[CMD_WR];
    strobes.isPre    = decVec[CMD_PRE];
    strobes.isLmr    = decVec[CMD_LMR];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdOut     <= '0;
      illegalCke <= 1'b0;
    end else begin
      cmdOut     <= decVec;
      illegalCke <= illegalNext;
    end
  end

  assert_onehot_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cmdOut, illegalCke}));

  assert_inhibit_R1: assert property (@(posedge clk) disable iff (!rstN)
    csN |=> (cmdOut == '0 && !illegalCke));

  assert_cke_fault_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && !cke && code != 3'b001) |=> (illegalCke && cmdOut == '0));

  assert_self_refresh_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && !cke && code == 3'b001) |=> cmdOut[CMD_SREF]);
endmodule

// File: rtl/sdram_cmd_dpath.sv
module sdram_cmd_dpath
  import sdram_cmd_pkg::*;
#(
  parameter int BANK_W     = 2,
  parameter int ADDR_W     = 13,
  parameter int COL_W      = 10,
  parameter int AP_BIT     = 10,
  parameter int MODE_W     = 12,
  parameter int RD_DQM_LAT = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobes,
  input  logic [BANK_W-1:0] bankIn,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              dqmIn,
  output logic [BANK_W-1:0] bankOut,
  output logic [ADDR_W-1:0] rowOut,
  output logic [COL_W-1:0]  colOut,
  output logic              autoPre,
  output logic              preAll,
  output logic              modeStrobe,
  output logic [MODE_W-1:0] modeOp,
  output logic              wrMaskEn,
  output logic              rdMaskEn
);
  localparam int PIPE_LEN = RD_DQM_LAT + 1;

  logic apBit;
  logic loadBank;
  logic [PIPE_LEN-1:0] dqmPipe;

  assign apBit    = addrIn[AP_BIT];
  assign loadBank = strobes.isAct | strobes.isAccess | (strobes.isPre & ~apBit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bankOut    <= '0;
      rowOut     <= '0;
      colOut     <= '0;
      autoPre    <= 1'b0;
      preAll     <= 1'b0;
      modeStrobe <= 1'b0;
      modeOp     <= '0;
    end else begin
      bankOut    <= loadBank ? bankIn : '0;
      rowOut     <= strobes.isAct ? addrIn : '0;
      colOut     <= strobes.isAccess ? addrIn[COL_W-1:0] : '0;
      autoPre    <= strobes.isAccess & apBit;
      preAll     <= strobes.isPre & apBit;
      modeStrobe <= strobes.isLmr;
      modeOp     <= strobes.isLmr ? addrIn[MODE_W-1:0] : '0;
    end
  end

  // stage 0 is the write mask; the last stage is the delayed read mask
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dqmPipe[0] <= 1'b0;
    else       dqmPipe[0] <= dqmIn;
  end

  for (genvar s = 1; s < PIPE_LEN; s++) begin : g_dqmStage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) dqmPipe[s] <= 1'b0;
      else       dqmPipe[s] <= dqmPipe[s-1];
    end
  end

  assign wrMaskEn = dqmPipe[0];
  assign rdMaskEn = dqmPipe[PIPE_LEN-1];

  if (RD_DQM_LAT == 2) begin : g_lagCheck
    assert_read_mask_lag_R10: assert property (@(posedge clk) disable iff (!rstN)
      rdMaskEn == $past(wrMaskEn, 2));
  end

  assert_col_idle_R11: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.isAccess |=> (colOut == '0 && !autoPre));
endmodule

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_cmd_pkg::*;
#(
  parameter int BANK_W     = 2,
  parameter int ADDR_W     = 13,
  parameter int COL_W      = 10,
  parameter int AP_BIT     = 10,
  parameter int MODE_W     = 12,
  parameter int RD_DQM_LAT = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               csN,
  input  logic               rasN,
  input  logic               casN,
  input  logic               weN,
  input  logic               cke,
  input  logic [BANK_W-1:0]  bankIn,
  input  logic [ADDR_W-1:0]  addrIn,
  input  logic               dqmIn,
  output logic [CMD_NUM-1:0] cmdOut,
  output logic               illegalCke,
  output logic [BANK_W-1:0]  bankOut,
  output logic [ADDR_W-1:0]  rowOut,
  output logic [COL_W-1:0]   colOut,
  output logic               autoPre,
  output logic               preAll,
  output logic               modeStrobe,
  output logic [MODE_W-1:0]  modeOp,
  output logic               wrMaskEn,
  output logic               rdMaskEn
);
  strobe_t strobes;

  sdram_cmd_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .csN        (csN),
    .rasN       (rasN),
    .casN       (casN),
    .weN        (weN),
    .cke        (cke),
    .strobes    (strobes),
    .cmdOut     (cmdOut),
    .illegalCke (illegalCke)
  );

  sdram_cmd_dpath #(
    .BANK_W     (BANK_W),
    .ADDR_W     (ADDR_W),
    .COL_W      (COL_W),
    .AP_BIT     (AP_BIT),
    .MODE_W     (MODE_W),
    .RD_DQM_LAT (RD_DQM_LAT)
  ) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .bankIn     (bankIn),
    .addrIn     (addrIn),
    .dqmIn      (dqmIn),
    .bankOut    (bankOut),
    .rowOut     (rowOut),
    .colOut     (colOut),
    .autoPre    (autoPre),
    .preAll     (preAll),
    .modeStrobe (modeStrobe),
    .modeOp     (modeOp),
    .wrMaskEn   (wrMaskEn),
    .rdMaskEn   (rdMaskEn)
  );

  assert_autopre_access_R4: assert property (@(posedge clk) disable iff (!rstN)
    autoPre |-> (cmdOut[CMD_RD] || cmdOut[CMD_WR]));

  assert_preall_bank_R5: assert property (@(posedge clk) disable iff (!rstN)
    preAll |-> (cmdOut[CMD_PRE] && bankOut == '0));

  assert_mode_strobe_R8: assert property (@(posedge clk) disable iff (!rstN)
    modeStrobe |-> cmdOut[CMD_LMR]);

  assert_row_active_R3: assert property (@(posedge clk) disable iff (!rstN)
    (rowOut != '0) |-> cmdOut[CMD_ACT]);
endmodule

// File: tb/sdram_cmd_decode_bench.sv
module sdram_cmd_decode_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1, rasN = 1'b1, casN = 1'b1, weN = 1'b1, cke = 1'b1;
  logic [1:0]  bankIn = '0;
  logic [12:0] addrIn = '0;
  logic dqmIn = 1'b0;
  logic [8:0]  cmdOut;
  logic illegalCke, autoPre, preAll, modeStrobe, wrMaskEn, rdMaskEn;
  logic [1:0]  bankOut;
  logic [12:0] rowOut;
  logic [9:0]  colOut;
  logic [11:0] modeOp;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_cmd_decode u_sdram_cmd_decode (
    .clk(clk), .rstN(rstN), .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .cke(cke), .bankIn(bankIn), .addrIn(addrIn), .dqmIn(dqmIn),
    .cmdOut(cmdOut), .illegalCke(illegalCke), .bankOut(bankOut),
    .rowOut(rowOut), .colOut(colOut), .autoPre(autoPre), .preAll(preAll),
    .modeStrobe(modeStrobe), .modeOp(modeOp), .wrMaskEn(wrMaskEn),
    .rdMaskEn(rdMaskEn)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // entered at a falling edge; sets pins, returns at the next falling edge
  task automatic drive(input logic cs, input logic [2:0] code, input logic ck,
                       input logic [1:0] ba, input logic [12:0] a, input logic dq);
    csN = cs; {rasN, casN, weN} = code; cke = ck;
    bankIn = ba; addrIn = a; dqmIn = dq;
    @(negedge clk);
  endtask

  // expected {illegal, command vector} from the decode table
  function automatic logic [9:0] expDecode(input logic cs, input logic ck,
                                           input logic [2:0] code);
    logic [8:0] v = '0;
    logic ill = 1'b0;
    if (!cs) begin
      if (!ck) begin
        if (code == 3'b001) v[7] = 1'b1; else ill = 1'b1;
      end else begin
        case (code)
          3'b111: v[0] = 1'b1;
          3'b011: v[1] = 1'b1;
          3'b101: v[2] = 1'b1;
          3'b100: v[3] = 1'b1;
          3'b110: v[4] = 1'b1;
          3'b010: v[5] = 1'b1;
          3'b001: v[6] = 1'b1;
          default: v[8] = 1'b1;
        endcase
      end
    end
    return {ill, v};
  endfunction

  task automatic testReset();
    csN = 1'b0; {rasN, casN, weN} = 3'b011; addrIn = 13'h1FFF; bankIn = 2'd3;
    dqmIn = 1'b1;
    repeat (3) @(negedge clk);
    // R11: all outputs held at zero during reset
    chk("R11", "reset cmd", 32'(cmdOut), 0);
    chk("R11", "reset fields", 32'({bankOut, rowOut, colOut, modeOp}), 0);
    chk("R11", "reset flags", 32'({illegalCke, autoPre, preAll, modeStrobe, wrMaskEn, rdMaskEn}), 0);
    csN = 1'b1; {rasN, casN, weN} = 3'b111; dqmIn = 1'b0; addrIn = '0; bankIn = '0;
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic testSweep();
    for (int cs = 0; cs < 2; cs++) begin
      for (int ck = 0; ck < 2; ck++) begin
        for (int c = 0; c < 8; c++) begin
          logic [9:0] e = expDecode(cs[0], ck[0], c[2:0]);
          string tag;
          drive(cs[0], c[2:0], ck[0], 2'd1, 13'h0123, 1'b0);
          if (cs != 0)          tag = "R1";
          else if (c == 1)      tag = "R6";
          else if (ck != 0)     tag = "R2";
          else                  tag = "R7";
          chk(tag, $sformatf("decode cs=%0d cke=%0d code=%0d", cs, ck, c),
              32'({illegalCke, cmdOut}), 32'(e));
        end
      end
    end
  endtask

  task automatic testActive();
    drive(1'b0, 3'b011, 1'b1, 2'd2, 13'h1ABC, 1'b0);
    chk("R3", "active row", 32'(rowOut), 32'h1ABC);
    chk("R3", "active bank", 32'(bankOut), 2);
    chk("R11", "active col", 32'(colOut), 0);
    drive(1'b0, 3'b111, 1'b1, 2'd2, 13'h1ABC, 1'b0);
    chk("R11", "nop clears row/bank", 32'({rowOut, bankOut}), 0);
  endtask

  task automatic testAccess();
    drive(1'b0, 3'b101, 1'b1, 2'd1, 13'h1EF5, 1'b0);
    chk("R4", "read col", 32'(colOut), 32'h2F5);
    chk("R4", "read bank", 32'(bankOut), 1);
    chk("R4", "read autoPre", 32'(autoPre), 1);
    chk("R11", "read row", 32'(rowOut), 0);
    drive(1'b0, 3'b100, 1'b1, 2'd3, 13'h0155, 1'b0);
    chk("R4", "write col", 32'(colOut), 32'h155);
    chk("R4", "write bank", 32'(bankOut), 3);
    chk("R4", "write autoPre", 32'(autoPre), 0);
  endtask

  task automatic testPrecharge();
    drive(1'b0, 3'b010, 1'b1, 2'd3, 13'h0000, 1'b0);
    chk("R5", "single bank", 32'(bankOut), 3);
    chk("R5", "single preAll", 32'(preAll), 0);
    drive(1'b0, 3'b010, 1'b1, 2'd2, 13'h0400, 1'b0);
    chk("R5", "all preAll", 32'(preAll), 1);
    chk("R5", "all bank ignored", 32'(bankOut), 0);
    chk("R5", "all no autoPre", 32'(autoPre), 0);
  endtask

  task automatic testMode();
    drive(1'b0, 3'b000, 1'b1, 2'd0, 13'h1A37, 1'b0);
    chk("R8", "mode strobe", 32'(modeStrobe), 1);
    chk("R8", "mode op", 32'(modeOp), 32'hA37);
    drive(1'b1, 3'b000, 1'b1, 2'd0, 13'h1A37, 1'b0);
    chk("R11", "mode cleared", 32'({modeStrobe, modeOp}), 0);
  endtask

  task automatic testMask();
    logic [7:0] seq = 8'b0100_1101; // applied from bit 0 upward
    drive(1'b1, 3'b111, 1'b1, 2'd0, 13'h0, 1'b0);
    drive(1'b1, 3'b111, 1'b1, 2'd0, 13'h0, 1'b0);
    for (int i = 0; i < 8; i++) begin
      logic expRd;
      drive(i[0], 3'b111, 1'b1, 2'd0, 13'h0, seq[i]);
      expRd = (i >= 2) ? seq[i-2] : 1'b0;
      chk("R9", $sformatf("write mask step %0d", i), 32'(wrMaskEn), 32'(seq[i]));
      chk("R10", $sformatf("read mask step %0d", i), 32'(rdMaskEn), 32'(expRd));
    end
  endtask

  initial begin
    testReset();
    testSweep();
    testActive();
    testAccess();
    testPrecharge();
    testMode();
    testMask();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule